// File: doc/BRIEF.md
# Serial DAC Host Write Sequencer

This block sits on the host side of a board and writes 14-bit codes to a serial voltage-output converter. A producer hands over a code through a valid/ready handshake. The block then drives the three-wire write frame: an active-low chip select, a serial clock, and data sent most significant bit first. Once chip select has risen, it can also pulse an active-low load strobe so that the converter copies the frame into its output latch.

Every minimum interval is enforced by counting system clock cycles. These intervals are: clock high and low time, chip select lead before the first rising edge, data setup, hold after the last rising edge, chip select high time between frames, and the delay and width of the load strobe. Each interval is set by a parameter in picoseconds and rounded up to whole cycles of a clock whose period is also a parameter. Data changes only on falling serial clock edges, so setup to the next rising edge is one full low phase. A parameter picks between pulsing the load strobe after each frame and holding it low permanently.

Top module: `dac_serial_host`

## Requirements
- R1: After reset, chip select is high, the serial clock is low, ready is high, and the load strobe is high when pulsing is enabled.
- R2: A code is accepted on a clock edge where valid and ready are both high. Ready stays low from the next cycle until the post-frame interval (and the load pulse, if enabled) has ended. With the default 8 ns clock, ready returns 8 cycles after chip select rises when pulsing is enabled and 4 cycles after it rises when pulsing is disabled. Valid held high while ready is low is ignored.
- R3: Each frame carries exactly 14 rising serial clock edges while chip select is low. The bits sampled on those edges, most significant first, equal the accepted code.
- R4: Each serial clock high phase and each low phase lasts at least ceil(20 ns / Tclk) cycles, which is 3 at the default clock.
- R5: The first rising serial clock edge comes at least ceil(15 ns / Tclk) cycles (2) after chip select falls.
- R6: Data changes only together with a falling serial clock edge, or when a frame opens, and is stable for at least ceil(15 ns / Tclk) cycles (2) before each rising edge.
- R7: Chip select rises at least ceil(20 ns / Tclk) cycles (3) after the last rising serial clock edge.
- R8: Chip select stays high for at least ceil(30 ns / Tclk) cycles (4) between frames.
- R9: With pulsing enabled, exactly one load strobe low pulse follows each frame. It begins at least ceil(30 ns / Tclk) cycles (4) after chip select rises and lasts at least 4 cycles.
- R10: With pulsing disabled, the load strobe stays low at all times, including during reset.
- R11: The serial clock is low whenever chip select is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| code_i | input | DATA_W | Code to write |
| valid_i | input | 1 | Code on code_i is offered |
| ready_o | output | 1 | Block can accept a code |
| cs_n_o | output | 1 | Active-low chip select |
| sclk_o | output | 1 | Serial clock |
| sdo_o | output | 1 | Serial data, MSB first |
| ldac_n_o | output | 1 | Active-low load strobe |

## Verification
All pins are registered. Chip select falls and the first data bit appears one edge after acceptance. With the default 8 ns clock, the first rising serial clock edge follows 3 cycles later, and each later bit takes 6 cycles. Chip select rises 3 cycles after the 14th rising edge, the load strobe falls 4 cycles after that and stays low for 4, and ready returns 8 cycles after chip select rises. The monitor samples the pins on the falling system clock edge and timestamps each pin transition by cycle number. Each interval is checked as a difference of those timestamps against minimums that the bench derives from nanosecond figures, and the ready return is checked against an exact count. Data words are rebuilt from the bits sampled at rising serial clock edges and compared with codes the driver queued.

// File: rtl/dsh_pkg.sv
package dsh_pkg;

  typedef enum logic [2:0] {
    S_IDLE,
    S_LOW,
    S_HIGH,
    S_POST,
    S_PULSE
  } dsh_state_t;

  // Whole clock cycles covering a time in picoseconds, at least one.
  function automatic int unsigned ps_to_cycles(input int unsigned t_ps,
                                               input int unsigned clk_ps);
    int unsigned n;
    n = (t_ps + clk_ps - 1) / clk_ps;
    return (n == 0) ? 1 : n;
  endfunction

  function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/dsh_timer.sv
module dsh_timer #(
  parameter int unsigned W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_i,
  input  logic [W-1:0] value_i,
  output logic         expired_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt_q <= '0;
    else if (load_i)         cnt_q <= value_i;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign expired_o = (cnt_q == '0);
endmodule

// File: rtl/dsh_shifter.sv
module dsh_shifter #(
  parameter int unsigned W = 14
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_i,
  input  logic [W-1:0] data_i,
  input  logic         shift_i,
  output logic         msb_o
);
  logic [W-1:0] sr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        sr_q <= '0;
    else if (load_i)   sr_q <= data_i;
    else if (shift_i)  sr_q <= {sr_q[W-2:0], 1'b0};
  end

  assign msb_o = sr_q[W-1];
endmodule

// File: rtl/dac_serial_host.sv
module dac_serial_host
  import dsh_pkg::*;
#(
  parameter int unsigned DATA_W        = 14,
  parameter int unsigned CLK_PERIOD_PS = 8000,
  parameter int unsigned T_HALF_PS     = 20000,
  parameter int unsigned T_LEAD_PS     = 15000,
  parameter int unsigned T_SETUP_PS    = 15000,
  parameter int unsigned T_TRAIL_PS    = 20000,
  parameter int unsigned T_GAP_PS      = 30000,
  parameter int unsigned T_LDLY_PS     = 30000,
  parameter int unsigned T_LDW_PS      = 30000,
  parameter bit          LOAD_PULSE_EN = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] code_i,
  input  logic              valid_i,
  output logic              ready_o,
  output logic              cs_n_o,
  output logic              sclk_o,
  output logic              sdo_o,
  output logic              ldac_n_o
);
  localparam int unsigned N_HALF      = ps_to_cycles(T_HALF_PS, CLK_PERIOD_PS);
  localparam int unsigned N_LOW       = max_u(N_HALF, ps_to_cycles(T_SETUP_PS, CLK_PERIOD_PS));
  localparam int unsigned N_FIRST_LOW = max_u(N_LOW, ps_to_cycles(T_LEAD_PS, CLK_PERIOD_PS));
  localparam int unsigned N_LAST_HIGH = max_u(N_HALF, ps_to_cycles(T_TRAIL_PS, CLK_PERIOD_PS));
  localparam int unsigned N_GAP       = ps_to_cycles(T_GAP_PS, CLK_PERIOD_PS);
  localparam int unsigned N_POST      = LOAD_PULSE_EN ?
                                        max_u(N_GAP, ps_to_cycles(T_LDLY_PS, CLK_PERIOD_PS)) : N_GAP;
  localparam int unsigned N_LDW       = ps_to_cycles(T_LDW_PS, CLK_PERIOD_PS);
  localparam int unsigned N_MAX       = max_u(max_u(N_FIRST_LOW, N_LAST_HIGH),
                                              max_u(max_u(N_LOW, N_POST), N_LDW));
  localparam int unsigned CNT_W       = $clog2(N_MAX + 1);
  localparam int unsigned BIT_W       = $clog2(DATA_W);
  localparam logic        LDAC_IDLE   = LOAD_PULSE_EN;

  dsh_state_t       state_q;
  logic [BIT_W-1:0] bit_q;
  logic             sclk_q, cs_n_q, ldac_n_q;

  // Named internal events, visible to the bound checker.
  logic             accept;
  logic             last_bit;
  logic             tmr_load;
  logic [CNT_W-1:0] tmr_val;
  logic             tmr_expired;
  logic             sh_load;
  logic             sh_shift;
  logic             frame_close;

  assign ready_o     = (state_q == S_IDLE);
  assign accept      = valid_i && ready_o;
  assign last_bit    = (bit_q == '0);
  assign frame_close = (state_q == S_HIGH) && tmr_expired && last_bit;

  always_comb begin
    tmr_load = 1'b0;
    tmr_val  = '0;
    sh_load  = 1'b0;
    sh_shift = 1'b0;
    unique case (state_q)
      S_IDLE: if (accept) begin
        tmr_load = 1'b1;
        tmr_val  = CNT_W'(N_FIRST_LOW - 1);
        sh_load  = 1'b1;
      end
      S_LOW: if (tmr_expired) begin
        tmr_load = 1'b1;
        tmr_val  = last_bit ? CNT_W'(N_LAST_HIGH - 1) : CNT_W'(N_HALF - 1);
      end
      S_HIGH: if (tmr_expired) begin
        tmr_load = 1'b1;
        if (last_bit) begin
          tmr_val = CNT_W'(N_POST - 1);
        end else begin
          tmr_val  = CNT_W'(N_LOW - 1);
          sh_shift = 1'b1;
        end
      end
      S_POST: if (tmr_expired && LOAD_PULSE_EN) begin
        tmr_load = 1'b1;
        tmr_val  = CNT_W'(N_LDW - 1);
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= S_IDLE;
      bit_q    <= '0;
      sclk_q   <= 1'b0;
      cs_n_q   <= 1'b1;
      ldac_n_q <= LDAC_IDLE;
    end else begin
      unique case (state_q)
        S_IDLE: if (accept) begin
          cs_n_q  <= 1'b0;
          sclk_q  <= 1'b0;
          bit_q   <= BIT_W'(DATA_W - 1);
          state_q <= S_LOW;
        end
        S_LOW: if (tmr_expired) begin
          sclk_q  <= 1'b1;
          state_q <= S_HIGH;
        end
        S_HIGH: if (tmr_expired) begin
          sclk_q <= 1'b0;
          if (last_bit) begin
            cs_n_q  <= 1'b1;
            state_q <= S_POST;
          end else begin
            bit_q   <= bit_q - 1'b1;
            state_q <= S_LOW;
          end
        end
        S_POST: if (tmr_expired) begin
          if (LOAD_PULSE_EN) begin
            ldac_n_q <= 1'b0;
            state_q  <= S_PULSE;
          end else begin
            state_q  <= S_IDLE;
          end
        end
        S_PULSE: if (tmr_expired) begin
          ldac_n_q <= 1'b1;
          state_q  <= S_IDLE;
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  dsh_timer #(.W(CNT_W)) timer_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .load_i    (tmr_load),
    .value_i   (tmr_val),
    .expired_o (tmr_expired)
  );

  dsh_shifter #(.W(DATA_W)) shifter_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .load_i  (sh_load),
    .data_i  (code_i),
    .shift_i (sh_shift),
    .msb_o   (sdo_o)
  );

  assign sclk_o   = sclk_q;
  assign cs_n_o   = cs_n_q;
  assign ldac_n_o = ldac_n_q;
endmodule

// File: rtl/dsh_chk.sv
module dsh_chk
  import dsh_pkg::*;
#(
  parameter int unsigned CLK_PERIOD_PS = 8000,
  parameter int unsigned T_HALF_PS     = 20000,
  parameter int unsigned T_GAP_PS      = 30000,
  parameter int unsigned T_LDLY_PS     = 30000
) (
  input logic clk,
  input logic rst_n,
  input logic cs_n,
  input logic sclk,
  input logic sdo,
  input logic ldac_n,
  input logic ready,
  input logic shift_evt,
  input logic frame_close
);
  localparam int unsigned N_HALF = ps_to_cycles(T_HALF_PS, CLK_PERIOD_PS);
  localparam int unsigned N_GAP  = ps_to_cycles(T_GAP_PS, CLK_PERIOD_PS);
  localparam int unsigned N_LDLY = ps_to_cycles(T_LDLY_PS, CLK_PERIOD_PS);
  localparam logic [15:0] SAT    = 16'hFFFF;

  logic [15:0] hi_run, lo_run, cs_hi_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_run    <= '0;
      lo_run    <= '0;
      cs_hi_run <= SAT;
    end else begin
      hi_run    <= sclk ? ((hi_run == SAT) ? SAT : hi_run + 1'b1) : '0;
      lo_run    <= (sclk || cs_n) ? '0 : ((lo_run == SAT) ? SAT : lo_run + 1'b1);
      cs_hi_run <= cs_n ? ((cs_hi_run == SAT) ? SAT : cs_hi_run + 1'b1) : '0;
    end
  end

  p_sclk_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> !sclk);
  p_busy_not_ready_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_n |-> !ready);
  p_sdo_stable_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sclk) |-> $stable(sdo));
  p_shift_on_fall_r6: assert property (@(posedge clk) disable iff (!rst_n)
    shift_evt |=> $fell(sclk));
  p_high_len_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sclk) |-> (hi_run >= 16'(N_HALF)));
  p_low_len_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sclk) |-> (lo_run >= 16'(N_HALF)));
  p_close_raises_cs_r7: assert property (@(posedge clk) disable iff (!rst_n)
    frame_close |=> cs_n);
  p_cs_gap_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cs_n) |-> (cs_hi_run >= 16'(N_GAP)));
  p_ldac_delay_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ldac_n) |-> (cs_n && cs_hi_run >= 16'(N_LDLY)));
endmodule

bind dac_serial_host dsh_chk #(
  .CLK_PERIOD_PS (CLK_PERIOD_PS),
  .T_HALF_PS     (T_HALF_PS),
  .T_GAP_PS      (T_GAP_PS),
  .T_LDLY_PS     (T_LDLY_PS)
) chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .cs_n        (cs_n_o),
  .sclk        (sclk_o),
  .sdo         (sdo_o),
  .ldac_n      (ldac_n_o),
  .ready       (ready_o),
  .shift_evt   (sh_shift),
  .frame_close (frame_close)
);

// File: tb/dac_serial_host_tb_top.sv
`timescale 1ns/1ps
module dac_serial_host_tb_top;
  localparam int CLK_NS = 8;

  function automatic int ceil_ns(input int t_ns);
    return (t_ns + CLK_NS - 1) / CLK_NS;
  endfunction

  localparam int E_HALF  = (20 + CLK_NS - 1) / CLK_NS;
  localparam int E_LEAD  = (15 + CLK_NS - 1) / CLK_NS;
  localparam int E_SETUP = (15 + CLK_NS - 1) / CLK_NS;
  localparam int E_TRAIL = (20 + CLK_NS - 1) / CLK_NS;
  localparam int E_GAP   = (30 + CLK_NS - 1) / CLK_NS;
  localparam int E_LDLY  = (30 + CLK_NS - 1) / CLK_NS;
  localparam int E_LDW   = (30 + CLK_NS - 1) / CLK_NS;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic [13:0] code, nl_code;
  logic valid = 1'b0, nl_valid = 1'b0;
  logic ready, cs_n, sclk, sdo, ldac_n;
  logic nl_ready, nl_cs_n, nl_sclk, nl_sdo, nl_ldac_n;

  dac_serial_host dut_i (
    .clk(clk), .rst_n(rst_n), .code_i(code), .valid_i(valid), .ready_o(ready),
    .cs_n_o(cs_n), .sclk_o(sclk), .sdo_o(sdo), .ldac_n_o(ldac_n)
  );

  dac_serial_host #(.LOAD_PULSE_EN(1'b0)) dut_nl_i (
    .clk(clk), .rst_n(rst_n), .code_i(nl_code), .valid_i(nl_valid), .ready_o(nl_ready),
    .cs_n_o(nl_cs_n), .sclk_o(nl_sclk), .sdo_o(nl_sdo), .ldac_n_o(nl_ldac_n)
  );

  int checks = 0, errors = 0;
  bit done = 1'b0;
  logic [13:0] exp_q[$];
  int sent = 0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Driver: offers a code, queues it as expected, optionally keeps valid high while busy.
  task automatic send(input logic [13:0] c, input bool_hold);
    @(negedge clk);
    while (!ready) @(negedge clk);
    code = c; valid = 1'b1;
    exp_q.push_back(c);
    sent++;
    @(negedge clk);
    check(!ready, "R2 ready low after accept", ready, 0);
    if (bool_hold) begin
      code = ~c;
      repeat (5) @(negedge clk);
    end
    valid = 1'b0;
  endtask

  // Monitor: timestamps pin transitions at the falling system clock edge.
  int cyc = 0;
  int t_csfall = -1000, t_csrise = -1000, t_rise = -1000, t_fall = -1000;
  int t_sdo = -1000, t_ldfall = -1000;
  int bits = 0, frames = 0, pulses = 0, r11_bad = 0, r2_bad = 0;
  logic [13:0] word = '0, cur_exp = '0;
  logic p_cs = 1'b1, p_sclk = 1'b0, p_sdo = 1'b0, p_ldac = 1'b1, p_ready = 1'b1;

  always @(negedge clk) begin
    if (rst_n) begin
      cyc++;
      if (sdo !== p_sdo) t_sdo = cyc;
      if (p_cs && !cs_n) begin
        check(cyc - t_csrise >= E_GAP, "R8 cs high gap", cyc - t_csrise, E_GAP);
        if (exp_q.size() == 0) check(1'b0, "R3 frame without code", 0, 1);
        else cur_exp = exp_q.pop_front();
        bits = 0; word = '0; t_csfall = cyc; t_fall = cyc;
      end
      if (!p_sclk && sclk && !cs_n) begin
        bits++;
        word = {word[12:0], sdo};
        check(cyc - t_fall >= E_HALF, "R4 sclk low time", cyc - t_fall, E_HALF);
        if (bits == 1)
          check(cyc - t_csfall >= E_LEAD, "R5 cs lead", cyc - t_csfall, E_LEAD);
        check(cyc - t_sdo >= E_SETUP, "R6 data setup", cyc - t_sdo, E_SETUP);
        t_rise = cyc;
      end
      if (p_sclk && !sclk) begin
        check(cyc - t_rise >= E_HALF, "R4 sclk high time", cyc - t_rise, E_HALF);
        t_fall = cyc;
      end
      if (!p_cs && cs_n) begin
        check(bits == 14, "R3 bit count", bits, 14);
        check(word == cur_exp, "R3 data word", word, cur_exp);
        check(cyc - t_rise >= E_TRAIL, "R7 cs trail", cyc - t_rise, E_TRAIL);
        frames++;
        t_csrise = cyc;
      end
      if (p_ldac && !ldac_n) begin
        check(cs_n && (cyc - t_csrise >= E_LDLY), "R9 load delay", cyc - t_csrise, E_LDLY);
        pulses++;
        t_ldfall = cyc;
      end
      if (!p_ldac && ldac_n)
        check(cyc - t_ldfall >= E_LDW, "R9 load width", cyc - t_ldfall, E_LDW);
      if (!p_ready && ready && frames > 0)
        check(cyc - t_csrise == E_LDLY + E_LDW, "R2 ready return", cyc - t_csrise, E_LDLY + E_LDW);
      if (cs_n && sclk) r11_bad++;
      if (!cs_n && ready) r2_bad++;
      p_cs = cs_n; p_sclk = sclk; p_sdo = sdo; p_ldac = ldac_n; p_ready = ready;
    end
  end

  task automatic send_nl(input logic [13:0] c);
    logic [13:0] w;
    int nb, ld_hi, n;
    logic ps;
    @(negedge clk);
    while (!nl_ready) @(negedge clk);
    nl_code = c; nl_valid = 1'b1;
    @(negedge clk);
    nl_valid = 1'b0;
    w = '0; nb = 0; ld_hi = 0; ps = 1'b0;
    while (!nl_cs_n) begin
      if (!ps && nl_sclk) begin w = {w[12:0], nl_sdo}; nb++; end
      if (nl_ldac_n) ld_hi++;
      ps = nl_sclk;
      @(negedge clk);
    end
    n = 0;
    while (!nl_ready) begin
      if (nl_ldac_n) ld_hi++;
      n++;
      @(negedge clk);
    end
    check(nb == 14 && w == c, "R3 no-load data", w, c);
    check(ld_hi == 0, "R10 strobe held low", ld_hi, 0);
    check(n == E_GAP, "R2 no-load ready return", n, E_GAP);
  endtask

  initial begin
    code = '0; nl_code = '0;
    repeat (3) @(negedge clk);
    check(cs_n && !sclk && ready && ldac_n, "R1 reset outputs",
          {cs_n, sclk, ready, ldac_n}, 4'b1011);
    check(!nl_ldac_n, "R10 strobe low in reset", nl_ldac_n, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(cs_n && !sclk && ready, "R1 idle after reset", {cs_n, sclk, ready}, 3'b101);
    send(14'h0000, 1'b0);
    send(14'h3FFF, 1'b0);
    send(14'h2AAA, 1'b1);   // R2: valid held high while busy must not start a frame
    send(14'h1555, 1'b0);
    send(14'h2000, 1'b0);
    send(14'h0001, 1'b0);
    for (int i = 0; i < 6; i++) send(14'((i * 14'h0B6D) ^ 14'h1234), 1'b0);
    @(negedge clk);
    while (!ready) @(negedge clk);
    repeat (6) @(negedge clk);
    check(frames == sent, "R3 frame count", frames, sent);
    check(pulses == frames, "R9 one pulse per frame", pulses, frames);
    check(r11_bad == 0, "R11 sclk low while idle", r11_bad, 0);
    check(r2_bad == 0, "R2 not ready while cs low", r2_bad, 0);
    check(exp_q.size() == 0, "R3 all codes sent", exp_q.size(), 0);
    send_nl(14'h2C3A);
    send_nl(14'h13C5);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule